// File: doc/BRIEF.md
# Write-Permission Guard for a Serial Memory

This block decides whether a write that a serial memory front end has already decoded may go ahead. The write can target the data array or the status register. The block holds three pieces of state:

- a volatile write-enable latch;
- a two-bit protected-range selector;
- a lock-enable bit.

The last two model non-volatile cells. The shift logic and the array itself lie outside the block. The front end presents one-cycle command strobes and the target byte address. In return it receives a grant pulse (array or status) or a deny pulse, and the live status byte that a status read would shift out.

The protected-range selector marks the top quarter, the top half or the whole array as read-only. A hardware lock applies when the external lock pin is driven low while the lock-enable bit is 1. The lock freezes the status register, and with it the range selector and the lock-enable bit. Unprotected addresses stay writable while the lock is applied.

A small sequencer models the programming time of an accepted write. From ST_READY, an accepted array write takes the transition "accept array write" to ST_ARRAY_PROG. An accepted status write takes "accept status write" to ST_STATUS_PROG. Either busy state counts PROG_CYCLES cycles and then takes "program done" back to ST_READY.

The non-volatile bits are cleared only by the power-on reset `por_n`. When NV_RETAIN is 0, the functional reset `rst_n` clears them as well.

Top module: `wp_guard`

## Requirements
- R1: After power-on reset the status byte reads 8'h00, so the write-enable latch is clear, there is no protected range, the lock-enable bit is 0 and the block is not busy.
- R2: A set-latch strobe sets the write-enable latch (status bit 1) and a clear-latch strobe clears it. If both strobes arrive in the same cycle, the clear wins.
- R3: An array write is granted only if the latch is set and the address is outside the protected range. The range codes are: 2'b00 none; 2'b01 addresses whose two top bits are 11; 2'b10 addresses whose top bit is 1; 2'b11 all addresses. The address check does not depend on the lock pin.
- R4: A status write is granted only if the latch is set and the hardware lock is not applied. The lock is applied when lock_pin_n is 0 and status bit 7 is 1. A granted status write loads bit 7 from stat_wdata[7] and the range code from stat_wdata[3:2].
- R5: The status byte has this layout: bit 7 lock-enable, bits 3:2 range code, bit 1 write-enable latch, bit 0 busy. Bits 6:4 always read 0.
- R6: Every processed write strobe (array or status) clears the write-enable latch, whether or not the write was granted.
- R7: A refused write produces a deny pulse exactly one cycle wide, in the cycle after the strobe. It gives no grant and leaves status bits 7 and 3:2 unchanged.
- R8: A granted write produces a one-cycle grant pulse in the cycle after the strobe. Status bit 0 is then 1 for exactly PROG_CYCLES cycles.
- R9: While busy, every command strobe is ignored. No pulse is produced and the latch does not change.
- R10: If strobes arrive together, the status write takes precedence over the array write, which is then dropped. Any write strobe takes precedence over the latch strobes.
- R11: With NV_RETAIN = 1, `rst_n` clears the latch and the sequencer but keeps status bits 7 and 3:2. `por_n` clears all of the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Functional reset, active low |
| lock_pin_n | input | 1 | Hardware lock pin; low requests the lock |
| cmd_set_latch | input | 1 | Set write-enable latch strobe |
| cmd_clr_latch | input | 1 | Clear write-enable latch strobe |
| cmd_wr_status | input | 1 | Status register write strobe |
| cmd_wr_array | input | 1 | Array byte write strobe |
| wr_addr | input | AW | Target array address |
| stat_wdata | input | 8 | New status byte for a status write |
| grant_array | output | 1 | Array write accepted (one-cycle pulse) |
| grant_status | output | 1 | Status write accepted (one-cycle pulse) |
| deny | output | 1 | Write refused (one-cycle pulse) |
| stat_rdata | output | 8 | Current status byte |

## Verification
Two kinds of event can fall in the same cycle.

- **Strobe collisions.** A set-latch strobe can meet a clear-latch strobe, and a status write can meet an array write. The bench raises each pair in one cycle. It judges the set/clear pair by the latch bit afterwards, and the write pair by seeing only a status grant and no array pulse. It also pairs a set-latch strobe with an array write while the latch is clear. That case must give a deny with the latch still clear.
- **Lock pin against the lock-enable bit.** These are sampled together at a status write. The bench sweeps every combination of pin level, lock-enable value and latch state. For each one it compares the pulse and the final status byte with values worked out arithmetically from R4.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_READY       = 2'd0,
        ST_ARRAY_PROG  = 2'd1,
        ST_STATUS_PROG = 2'd2
    } seq_state_t;

    // Protected-range selector encoding
    typedef enum logic [1:0] {
        RANGE_NONE    = 2'b00,
        RANGE_QUARTER = 2'b01,
        RANGE_HALF    = 2'b10,
        RANGE_ALL     = 2'b11
    } range_sel_t;

    // Resolved command for one cycle
    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_SET_LATCH = 3'd1,
        OP_CLR_LATCH = 3'd2,
        OP_WR_STATUS = 3'd3,
        OP_WR_ARRAY  = 3'd4
    } cmd_op_t;

    localparam int STAT_W = 8;

    // Status byte: lock-enable at 7, range at 3:2, latch at 1, busy at 0
    function automatic logic [STAT_W-1:0] pack_status(
        input logic       lock_en,
        input logic [1:0] range_sel,
        input logic       latch,
        input logic       busy
    );
        return {lock_en, 3'b000, range_sel, latch, busy};
    endfunction

endpackage

// File: rtl/wp_cmd_arb.sv
module wp_cmd_arb
    import wp_guard_pkg::*;
(
    input  logic    set_latch,
    input  logic    clr_latch,
    input  logic    wr_status,
    input  logic    wr_array,
    output cmd_op_t op
);

    // Priority: status write, array write, clear latch, set latch
    always_comb begin
        if (wr_status) begin
            op = OP_WR_STATUS;
        end else if (wr_array) begin
            op = OP_WR_ARRAY;
        end else if (clr_latch) begin
            op = OP_CLR_LATCH;
        end else if (set_latch) begin
            op = OP_SET_LATCH;
        end else begin
            op = OP_NONE;
        end
    end

endmodule

// File: rtl/wp_range_check.sv
module wp_range_check
    import wp_guard_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    range_sel,
    output logic          in_range
);

    range_sel_t sel;
    assign sel = range_sel_t'(range_sel);

    generate
        if (AW >= 2) begin : g_wide
            always_comb begin
                unique case (sel)
                    RANGE_NONE:    in_range = 1'b0;
                    RANGE_QUARTER: in_range = &addr[AW-1:AW-2];
                    RANGE_HALF:    in_range = addr[AW-1];
                    RANGE_ALL:     in_range = 1'b1;
                    default:       in_range = 1'b1;
                endcase
            end
        end else begin : g_narrow
            // With a two-entry array the quarter rounds up to the top half
            always_comb begin
                unique case (sel)
                    RANGE_NONE:    in_range = 1'b0;
                    RANGE_QUARTER: in_range = addr[AW-1];
                    RANGE_HALF:    in_range = addr[AW-1];
                    RANGE_ALL:     in_range = 1'b1;
                    default:       in_range = 1'b1;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/wp_nv_regs.sv
module wp_nv_regs (
    input  logic       clk,
    input  logic       nv_rst_n,
    input  logic       load,
    input  logic       d_lock_en,
    input  logic [1:0] d_range,
    output logic       lock_en,
    output logic [1:0] range_sel
);

    always_ff @(posedge clk or negedge nv_rst_n) begin
        if (!nv_rst_n) begin
            lock_en   <= 1'b0;
            range_sel <= 2'b00;
        end else if (load) begin
            lock_en   <= d_lock_en;
            range_sel <= d_range;
        end
    end

endmodule

// File: rtl/wp_seq.sv
module wp_seq
    import wp_guard_pkg::*;
#(
    parameter int PROG_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  cmd_op_t op,
    input  logic    addr_locked,
    input  logic    hw_lock,
    output logic    busy,
    output logic    latch,
    output logic    grant_array,
    output logic    grant_status,
    output logic    deny,
    output logic    nv_load
);

    localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(PROG_CYCLES - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          latch_q, latch_d;
    logic          ready;
    logic          arr_ok, arr_bad, stat_ok, stat_bad;

    assign ready    = (state_q == ST_READY);
    assign arr_ok   = ready && (op == OP_WR_ARRAY)  &&  latch_q && !addr_locked;
    assign arr_bad  = ready && (op == OP_WR_ARRAY)  && !(latch_q && !addr_locked);
    assign stat_ok  = ready && (op == OP_WR_STATUS) &&  latch_q && !hw_lock;
    assign stat_bad = ready && (op == OP_WR_STATUS) && !(latch_q && !hw_lock);

    // Next-state, counter and latch logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        latch_d = latch_q;
        unique case (state_q)
            ST_READY: begin
                if (arr_ok) begin
                    state_d = ST_ARRAY_PROG;
                    cnt_d   = CNT_LOAD;
                end else if (stat_ok) begin
                    state_d = ST_STATUS_PROG;
                    cnt_d   = CNT_LOAD;
                end
                unique case (op)
                    OP_SET_LATCH: latch_d = 1'b1;
                    OP_CLR_LATCH: latch_d = 1'b0;
                    OP_WR_STATUS: latch_d = 1'b0;
                    OP_WR_ARRAY:  latch_d = 1'b0;
                    default:      latch_d = latch_q;
                endcase
            end
            ST_ARRAY_PROG, ST_STATUS_PROG: begin
                if (cnt_q == '0) begin
                    state_d = ST_READY;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_READY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
            latch_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            latch_q <= latch_d;
        end
    end

    // Registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_array  <= 1'b0;
            grant_status <= 1'b0;
            deny         <= 1'b0;
        end else begin
            grant_array  <= arr_ok;
            grant_status <= stat_ok;
            deny         <= arr_bad || stat_bad;
        end
    end

    assign busy    = !ready;
    assign latch   = latch_q;
    assign nv_load = stat_ok;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PROG_CYCLES = 4,
    parameter bit NV_RETAIN   = 1'b1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              lock_pin_n,
    input  logic              cmd_set_latch,
    input  logic              cmd_clr_latch,
    input  logic              cmd_wr_status,
    input  logic              cmd_wr_array,
    input  logic [AW-1:0]     wr_addr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              grant_array,
    output logic              grant_status,
    output logic              deny,
    output logic [STAT_W-1:0] stat_rdata
);

    cmd_op_t    op;
    logic       vol_rst_n;
    logic       nv_rst_n;
    logic       lock_en;
    logic [1:0] range_sel;
    logic       addr_locked;
    logic       hw_lock;
    logic       busy;
    logic       latch;
    logic       nv_load;

    assign vol_rst_n = rst_n & por_n;

    generate
        if (NV_RETAIN) begin : g_retain
            assign nv_rst_n = por_n;
        end else begin : g_volatile
            assign nv_rst_n = vol_rst_n;
        end
    endgenerate

    assign hw_lock = !lock_pin_n && lock_en;

    wp_cmd_arb u_arb (
        .set_latch (cmd_set_latch),
        .clr_latch (cmd_clr_latch),
        .wr_status (cmd_wr_status),
        .wr_array  (cmd_wr_array),
        .op        (op)
    );

    wp_range_check #(.AW(AW)) u_range (
        .addr      (wr_addr),
        .range_sel (range_sel),
        .in_range  (addr_locked)
    );

    wp_nv_regs u_nv (
        .clk       (clk),
        .nv_rst_n  (nv_rst_n),
        .load      (nv_load),
        .d_lock_en (stat_wdata[7]),
        .d_range   (stat_wdata[3:2]),
        .lock_en   (lock_en),
        .range_sel (range_sel)
    );

    wp_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (vol_rst_n),
        .op           (op),
        .addr_locked  (addr_locked),
        .hw_lock      (hw_lock),
        .busy         (busy),
        .latch        (latch),
        .grant_array  (grant_array),
        .grant_status (grant_status),
        .deny         (deny),
        .nv_load      (nv_load)
    );

    assign stat_rdata = pack_status(lock_en, range_sel, latch, busy);

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       lock_pin_n,
    input logic [7:0] stat_wdata,
    input logic       grant_array,
    input logic       grant_status,
    input logic       deny,
    input logic [7:0] stat_rdata
);

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $onehot0({grant_array, grant_status, deny}));

    // R6
    latch_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (grant_array || grant_status || deny) |-> !stat_rdata[1]);

    // R3
    array_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        grant_array |-> $past(stat_rdata[1]));

    // R4
    lock_blocks_status_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        grant_status |-> !($past(stat_rdata[7]) && !$past(lock_pin_n)));

    // R4
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        grant_status |-> (stat_rdata[7] == $past(stat_wdata[7]) &&
                          stat_rdata[3:2] == $past(stat_wdata[3:2])));

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !grant_status |-> $stable({stat_rdata[7], stat_rdata[3:2]}));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $past(stat_rdata[0]) |-> !(grant_array || grant_status || deny));

    // R8
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (grant_array || grant_status) |-> stat_rdata[0]);

endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .lock_pin_n   (lock_pin_n),
    .stat_wdata   (stat_wdata),
    .grant_array  (grant_array),
    .grant_status (grant_status),
    .deny         (deny),
    .stat_rdata   (stat_rdata)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int PC         = 2;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          por_n, rst_n, lock_pin_n;
    logic          c_set, c_clr, c_ws, c_wa;
    logic [AW-1:0] addr;
    logic [7:0]    wdat;
    logic          ga, gs, dn;
    logic [7:0]    st;

    int n_chk  = 0;
    int n_fail = 0;

    wp_guard #(.AW(AW), .PROG_CYCLES(PC), .NV_RETAIN(1'b1)) dut (
        .clk           (clk),
        .por_n         (por_n),
        .rst_n         (rst_n),
        .lock_pin_n    (lock_pin_n),
        .cmd_set_latch (c_set),
        .cmd_clr_latch (c_clr),
        .cmd_wr_status (c_ws),
        .cmd_wr_array  (c_wa),
        .wr_addr       (addr),
        .stat_wdata    (wdat),
        .grant_array   (ga),
        .grant_status  (gs),
        .deny          (dn),
        .stat_rdata    (st)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit in_range(int sel, int a);
        case (sel)
            0:       return 1'b0;
            1:       return a >= (DEPTH * 3) / 4;
            2:       return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives strobes for one edge, returns pulses seen after it
    task automatic issue(input bit s, input bit c, input bit ws, input bit wa,
                         input logic [AW-1:0] a, input logic [7:0] d,
                         output logic o_ga, output logic o_gs, output logic o_dn);
        c_set = s; c_clr = c; c_ws = ws; c_wa = wa; addr = a; wdat = d;
        @(negedge clk);
        o_ga = ga; o_gs = gs; o_dn = dn;
        c_set = 1'b0; c_clr = 1'b0; c_ws = 1'b0; c_wa = 1'b0;
    endtask

    task automatic wait_ready();
        while (st[0]) @(negedge clk);
    endtask

    task automatic program_status(input bit en, input logic [1:0] sel);
        logic x1, x2, x3;
        lock_pin_n = 1'b1;
        issue(1, 0, 0, 0, '0, 8'h00, x1, x2, x3);
        issue(0, 0, 1, 0, '0, {en, 3'b000, sel, 2'b00}, x1, x2, x3);
        wait_ready();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic o_a, o_s, o_d;
        int   cnt;
        por_n = 1'b0; rst_n = 1'b0; lock_pin_n = 1'b1;
        c_set = 1'b0; c_clr = 1'b0; c_ws = 1'b0; c_wa = 1'b0;
        addr = '0; wdat = 8'h00;
        repeat (4) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after power-on", st, 8'h00);

        // Array write with latch clear is refused
        issue(0, 0, 0, 1, 4'd0, 8'h00, o_a, o_s, o_d);
        chk("R3 no latch grant", o_a, 0);
        chk("R7 no latch deny", o_d, 1);
        @(negedge clk);
        chk("R7 deny one cycle wide", dn, 0);

        // Latch set and clear
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        chk("R2 set latch", st[1], 1);
        chk("R2 set latch no pulse", {o_a, o_s, o_d}, 0);
        issue(0, 1, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        chk("R2 clear latch", st[1], 0);
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        issue(1, 1, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        chk("R2 clear wins over set", st[1], 0);

        // Status layout
        program_status(1'b1, 2'b11);
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        chk("R5 layout en=1 range=11 latch=1", st, 8'h8E);
        issue(0, 1, 0, 0, '0, 8'h00, o_a, o_s, o_d);

        // Array write sweep over range, lock-enable, pin and address
        for (int sel = 0; sel < 4; sel++) begin
            for (int en = 0; en < 2; en++) begin
                for (int pin = 0; pin < 2; pin++) begin
                    for (int a = 0; a < DEPTH; a++) begin
                        bit exp_g;
                        program_status(en[0], sel[1:0]);
                        lock_pin_n = pin[0];
                        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
                        issue(0, 0, 0, 1, AW'(a), 8'h00, o_a, o_s, o_d);
                        exp_g = !in_range(sel, a);
                        chk($sformatf("R3 grant sel=%0d en=%0d pin=%0d a=%0d", sel, en, pin, a),
                            o_a, exp_g);
                        chk($sformatf("R7 deny sel=%0d a=%0d", sel, a), o_d, !exp_g);
                        chk($sformatf("R6 latch after write a=%0d", a), st[1], 0);
                        if (exp_g) chk("R8 busy after grant", st[0], 1);
                        chk($sformatf("R7 status kept sel=%0d", sel),
                            {st[7], st[3:2]}, {en[0], sel[1:0]});
                        wait_ready();
                        lock_pin_n = 1'b1;
                    end
                end
            end
        end

        // Status write sweep over lock-enable, pin and latch
        for (int en = 0; en < 2; en++) begin
            for (int pin = 0; pin < 2; pin++) begin
                for (int w = 0; w < 2; w++) begin
                    bit         exp_g;
                    logic [7:0] e;
                    program_status(en[0], 2'b01);
                    lock_pin_n = pin[0];
                    if (w != 0) issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
                    issue(0, 0, 1, 0, '0, {~en[0], 3'b111, 2'b10, 2'b11}, o_a, o_s, o_d);
                    exp_g = (w != 0) && !(pin == 0 && en == 1);
                    chk($sformatf("R4 grant en=%0d pin=%0d latch=%0d", en, pin, w), o_s, exp_g);
                    chk($sformatf("R4 deny en=%0d pin=%0d latch=%0d", en, pin, w), o_d, !exp_g);
                    wait_ready();
                    e = exp_g ? {~en[0], 3'b000, 2'b10, 2'b00} : {en[0], 3'b000, 2'b01, 2'b00};
                    chk($sformatf("R4 R5 status en=%0d pin=%0d latch=%0d", en, pin, w), st, e);
                    lock_pin_n = 1'b1;
                end
            end
        end

        // Busy duration
        program_status(1'b0, 2'b00);
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        issue(0, 0, 0, 1, 4'd5, 8'h00, o_a, o_s, o_d);
        chk("R8 grant pulse", o_a, 1);
        cnt = 0;
        while (st[0]) begin
            cnt++;
            if (cnt == 1) chk("R8 grant one cycle wide", ga, 1);
            @(negedge clk);
            if (cnt == 1) chk("R8 grant cleared", ga, 0);
        end
        chk("R8 busy length", cnt, PC);

        // Strobes during busy are ignored
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        issue(0, 0, 0, 1, 4'd3, 8'h00, o_a, o_s, o_d);
        chk("R9 setup grant", o_a, 1);
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        chk("R9 set during busy no pulse", {o_a, o_s, o_d}, 0);
        issue(0, 0, 0, 1, 4'd3, 8'h00, o_a, o_s, o_d);
        chk("R9 write during busy no pulse", {o_a, o_s, o_d}, 0);
        wait_ready();
        chk("R9 latch unchanged by busy strobes", st[1], 0);

        // Collisions
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        issue(0, 0, 1, 1, 4'd0, 8'h00, o_a, o_s, o_d);
        chk("R10 status wins over array", {o_a, o_s, o_d}, 3'b010);
        wait_ready();
        issue(1, 0, 0, 1, 4'd0, 8'h00, o_a, o_s, o_d);
        chk("R10 write beats set: deny", o_d, 1);
        chk("R10 write beats set: latch", st[1], 0);

        // Reset retention
        program_status(1'b1, 2'b10);
        issue(1, 0, 0, 0, '0, 8'h00, o_a, o_s, o_d);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 functional reset keeps bits", st, 8'h88);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R11 power-on reset clears all", st, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule